// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block drives one 8-bit NAND flash bus cycle at a time. A requester presents a single-cycle request with an access-type code (command latch, address latch, data write or data read) and, for write-type cycles, the byte to drive. The block then steps through a setup phase, a strobe pulse on the write or read enable, a hold phase and an optional ready-wait, after which it samples the device ready/busy pin and pulses a done output. Read cycles also return the byte captured from the flash data bus.

All timing comes from a 32-bit configuration word holding eight 4-bit fields, one group of four for read cycles and one for write-type cycles (command, address and data write all use the write group). Phase counts are loaded from a snapshot of that word taken when a cycle starts. A single request that arrives while a cycle runs is parked and started as soon as the block returns to idle.

Top module: `nand_cycle_timer`

## Requirements
- R1: After reset, with force_ce_i low, cle_o and ale_o are 0, we_no, re_no and ce_no are 1, done_o is 0, accept_o is 1 and rdata_o is 0.
- R2: Timing word fields (value n): read setup [3:0], read hold [7:4], read width [11:8], read ready-wait [15:12]; write setup [19:16], write hold [23:20], write width [27:24], write ready-wait [31:28]. With the request sampled at clock edge E0, the setup phase (strobe high, ce_no low) lasts setup+1 clocks, so the strobe first goes low in the cycle after edge E(setup+1).
- R3: The strobe stays low for width+1 clocks. kind_i codes: 0 command, 1 address, 2 data write pulse we_no; 3 data read pulses re_no. The other strobe stays high.
- R4: After the strobe rises, ce_no stays low for hold+1 more clocks (hold phase).
- R5: After the hold phase the block waits 2*n clocks (n = ready-wait field; no wait when n is 0), then done_o is high for exactly one clock.
- R6: cle_o is high throughout setup, pulse and hold of a command cycle, ale_o likewise for an address cycle, and neither is high in data cycles.
- R7: During setup, pulse and hold of a write-type cycle nand_data_oe_o is 1 and nand_data_o carries wdata_i; in a read cycle nand_data_oe_o stays 0 and rdata_o takes nand_data_i as sampled at the clock edge where re_no rises.
- R8: ready_o follows ready_pin_i (one register) while idle, stays frozen during a cycle, and at done shows the pin value sampled at the end of the ready-wait.
- R9: accept_o is 0 from the edge that starts a cycle until the block is idle again; one request arriving while busy is kept and executed after the current cycle.
- R10: ce_no is held low whenever force_ce_i is 1, including between cycles; otherwise it is low only during setup, pulse and hold.
- R11: soft_rst_i, sampled at a clock edge, aborts any cycle and parked request: strobes go inactive, accept_o returns to 1 and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous return to idle |
| timing_i | input | 32 | Packed timing fields |
| req_i | input | 1 | Single-cycle access request |
| kind_i | input | 2 | Access type code |
| wdata_i | input | 8 | Byte for command, address or data write |
| force_ce_i | input | 1 | Hold chip enable asserted |
| ready_pin_i | input | 1 | Device ready/busy pin |
| nand_data_i | input | 8 | Flash data bus, inbound |
| nand_data_o | output | 8 | Flash data bus, outbound |
| nand_data_oe_o | output | 1 | Outbound data enable |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write enable, active low |
| re_no | output | 1 | Read enable, active low |
| ce_no | output | 1 | Chip enable, active low |
| accept_o | output | 1 | Block can take a request |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| rdata_o | output | 8 | Captured read byte |
| ready_o | output | 1 | Sampled ready status |

## Verification
On every cycle the assertions check phase ordering and exclusivity: done is a single-clock pulse, a strobe low implies accept is low, a latch enable never rises together with a strobe pulse, the data bus is never driven while re_no is low, a soft reset leaves strobes inactive, and the phase counter never wraps. The exact phase lengths for each timing field, selection of the read versus write field group, the capture instant of read data, the ready sampling point and the parking of a busy-time request depend on programmed values and so are shown only by the bench scenarios, which measure every phase in clocks.

// File: rtl/nct_pkg.sv
package nct_pkg;
  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_WR   = 2'd2,
    KIND_RD   = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_WAIT,
    PH_DONE
  } phase_e;

  localparam int unsigned NUM_FIELDS = 4;
endpackage

// File: rtl/nct_field_sel.sv
module nct_field_sel #(
  parameter int unsigned FIELD_W = 4
) (
  input  logic [8*FIELD_W-1:0] timing_i,
  input  logic                 rd_i,
  output logic [FIELD_W-1:0]   setup_o,
  output logic [FIELD_W-1:0]   hold_o,
  output logic [FIELD_W-1:0]   width_o,
  output logic [FIELD_W-1:0]   rwait_o
);
  localparam int unsigned HALF_W = nct_pkg::NUM_FIELDS * FIELD_W;
  localparam int unsigned TW_W   = 2 * HALF_W;

  logic [HALF_W-1:0]  half;
  logic [FIELD_W-1:0] fld [nct_pkg::NUM_FIELDS];

  // low half: read group, high half: write group
  assign half = rd_i ? timing_i[HALF_W-1:0] : timing_i[TW_W-1:HALF_W];

  for (genvar i = 0; i < nct_pkg::NUM_FIELDS; i++) begin : g_fld
    assign fld[i] = half[i*FIELD_W +: FIELD_W];
  end

  assign setup_o = fld[0];
  assign hold_o  = fld[1];
  assign width_o = fld[2];
  assign rwait_o = fld[3];
endmodule

// File: rtl/nct_down_ctr.sv
module nct_down_ctr #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (load_i)  cnt_q <= val_i;
    else if (dec_i)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R2
  ctr_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && !clr_i) |-> (cnt_q != '0));
endmodule

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned FIELD_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 soft_rst_i,
  input  logic [8*FIELD_W-1:0] timing_i,
  input  logic                 req_i,
  input  logic [1:0]           kind_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 force_ce_i,
  input  logic                 ready_pin_i,
  input  logic [DATA_W-1:0]    nand_data_i,
  output logic [DATA_W-1:0]    nand_data_o,
  output logic                 nand_data_oe_o,
  output logic                 cle_o,
  output logic                 ale_o,
  output logic                 we_no,
  output logic                 re_no,
  output logic                 ce_no,
  output logic                 accept_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 ready_o
);
  import nct_pkg::*;

  localparam int unsigned CNT_W = FIELD_W + 1;

  phase_e              ph_q, ph_d;
  kind_e               kind_q, pend_kind_q, start_kind;
  logic                pend_q;
  logic [DATA_W-1:0]   wdata_q, pend_data_q, start_data;
  logic [FIELD_W-1:0]  sel_setup, sel_hold, sel_width, sel_rwait;
  logic [FIELD_W-1:0]  hold_q, width_q, rwait_q;
  logic                start, ctr_zero, ctr_ld, ctr_dec, in_bus, to_done;
  logic [CNT_W-1:0]    ctr_val;
  logic [DATA_W-1:0]   rdata_q;
  logic                ready_q;

  assign start      = (ph_q == PH_IDLE) && (pend_q || req_i);
  assign start_kind = pend_q ? pend_kind_q : kind_e'(kind_i);
  assign start_data = pend_q ? pend_data_q : wdata_i;

  nct_field_sel #(.FIELD_W(FIELD_W)) i_field_sel (
    .timing_i (timing_i),
    .rd_i     (start_kind == KIND_RD),
    .setup_o  (sel_setup),
    .hold_o   (sel_hold),
    .width_o  (sel_width),
    .rwait_o  (sel_rwait)
  );

  always_comb begin
    ph_d    = ph_q;
    ctr_ld  = 1'b0;
    ctr_val = '0;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        ph_d = PH_SETUP; ctr_ld = 1'b1; ctr_val = CNT_W'(sel_setup);
      end
      PH_SETUP: if (ctr_zero) begin
        ph_d = PH_PULSE; ctr_ld = 1'b1; ctr_val = CNT_W'(width_q);
      end
      PH_PULSE: if (ctr_zero) begin
        ph_d = PH_HOLD; ctr_ld = 1'b1; ctr_val = CNT_W'(hold_q);
      end
      PH_HOLD: if (ctr_zero) begin
        ph_d    = (rwait_q == '0) ? PH_DONE : PH_WAIT;
        ctr_ld  = 1'b1;
        ctr_val = {rwait_q, 1'b0} - CNT_W'(1);  // 2n clocks of wait
      end
      PH_WAIT: if (ctr_zero) ph_d = PH_DONE;
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  assign ctr_dec = (ph_q inside {PH_SETUP, PH_PULSE, PH_HOLD, PH_WAIT}) && !ctr_zero;
  assign to_done = (ph_d == PH_DONE) && (ph_q != PH_DONE);

  nct_down_ctr #(.W(CNT_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_rst_i),
    .load_i (ctr_ld),
    .val_i  (ctr_val),
    .dec_i  (ctr_dec),
    .zero_o (ctr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      kind_q      <= KIND_CMD;
      wdata_q     <= '0;
      hold_q      <= '0;
      width_q     <= '0;
      rwait_q     <= '0;
      pend_q      <= 1'b0;
      pend_kind_q <= KIND_CMD;
      pend_data_q <= '0;
      rdata_q     <= '0;
      ready_q     <= 1'b0;
    end else if (soft_rst_i) begin
      ph_q   <= PH_IDLE;
      pend_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (start) begin
        kind_q  <= start_kind;
        wdata_q <= start_data;
        hold_q  <= sel_hold;
        width_q <= sel_width;
        rwait_q <= sel_rwait;
      end
      // park one request that arrives while busy
      if (start && pend_q) pend_q <= 1'b0;
      else if (req_i && !pend_q && ph_q != PH_IDLE) begin
        pend_q      <= 1'b1;
        pend_kind_q <= kind_e'(kind_i);
        pend_data_q <= wdata_i;
      end
      if (ph_q == PH_PULSE && ctr_zero && kind_q == KIND_RD) rdata_q <= nand_data_i;
      if (ph_q == PH_IDLE || to_done) ready_q <= ready_pin_i;
    end
  end

  assign in_bus         = ph_q inside {PH_SETUP, PH_PULSE, PH_HOLD};
  assign cle_o          = in_bus && (kind_q == KIND_CMD);
  assign ale_o          = in_bus && (kind_q == KIND_ADDR);
  assign we_no          = !((ph_q == PH_PULSE) && (kind_q != KIND_RD));
  assign re_no          = !((ph_q == PH_PULSE) && (kind_q == KIND_RD));
  assign ce_no          = !(in_bus || force_ce_i);
  assign nand_data_oe_o = in_bus && (kind_q != KIND_RD);
  assign nand_data_o    = wdata_q;
  assign done_o         = (ph_q == PH_DONE);
  assign accept_o       = (ph_q == PH_IDLE) && !pend_q;
  assign rdata_o        = rdata_q;
  assign ready_o        = ready_q;

  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  busy_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !re_no) |-> !accept_o);
  // R11
  soft_rst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (we_no && re_no && !done_o));
  // R7
  rd_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !nand_data_oe_o);
  // R2
  latch_before_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cle_o) || $rose(ale_o)) |-> (we_no && re_no));
  // R4
  hold_after_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    $rose(we_no) |-> (!ce_no && !done_o));
endmodule

// File: tb/test_nand_cycle_timer.sv
module test_nand_cycle_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [31:0] timing = '0;
  logic        req = 1'b0;
  logic [1:0]  kind = '0;
  logic [7:0]  wdata = '0;
  logic        force_ce = 1'b0;
  logic        ready_pin = 1'b0;
  logic [7:0]  din = '0;
  logic [7:0]  dout, rdata;
  logic        oe, cle, ale, we_n, re_n, ce_n, accept, done, ready;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  nand_cycle_timer i_nand_cycle_timer (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .timing_i(timing),
    .req_i(req), .kind_i(kind), .wdata_i(wdata), .force_ce_i(force_ce),
    .ready_pin_i(ready_pin), .nand_data_i(din), .nand_data_o(dout),
    .nand_data_oe_o(oe), .cle_o(cle), .ale_o(ale), .we_no(we_n), .re_no(re_n),
    .ce_no(ce_n), .accept_o(accept), .done_o(done), .rdata_o(rdata), .ready_o(ready)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int ws, wh, ww, wr, rs, rh, rw, rr);
    return {wr[3:0], ww[3:0], wh[3:0], ws[3:0], rr[3:0], rw[3:0], rh[3:0], rs[3:0]};
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(!cle && !ale && we_n && re_n && !done, "R1 strobes", {cle, ale, we_n, re_n, done}, 5'b00110);
    chk(ce_n && accept && rdata == 0, "R1 ce/accept/rdata", {ce_n, accept}, 2'b11);
    force_ce = 1'b1; #1;
    chk(ce_n == 1'b0, "R10 forced idle", ce_n, 0);
    force_ce = 1'b0; #1;
    chk(ce_n == 1'b1, "R10 released idle", ce_n, 1);
  endtask

  // full cycle measured phase by phase
  task automatic run_cycle(input logic [1:0] k, input logic [7:0] wd, input logic [31:0] tw,
                           input int flip_k, input logic [7:0] rd);
    int s, w, h, r, t, bus;
    int first_low = 0, low_cnt = 0, bus_end = 0, cle_cnt = 0, ale_cnt = 0;
    int done_cnt = 0, done_k = 0;
    bit other_bad = 0, oe_bad = 0, rdy_bad = 0, done_rdy = 0, acc1 = 1, acc_end = 0;
    logic strobe, other;
    if (k == 2'd3) begin
      s = tw[3:0]; h = tw[7:4]; w = tw[11:8]; r = tw[15:12];
    end else begin
      s = tw[19:16]; h = tw[23:20]; w = tw[27:24]; r = tw[31:28];
    end
    t = s + w + h + 3 + 2 * r;
    bus = s + w + h + 3;
    ready_pin = 1'b0; din = ~rd;
    repeat (2) @(negedge clk);
    timing = tw; kind = k; wdata = wd; req = 1'b1;
    for (int kk = 1; kk <= t + 3; kk++) begin
      @(negedge clk);
      req = 1'b0;
      strobe = (k == 2'd3) ? re_n : we_n;
      other  = (k == 2'd3) ? we_n : re_n;
      if (kk == 1) acc1 = accept;
      if (kk == t + 2) acc_end = accept;
      if (!other) other_bad = 1;
      if (!strobe) begin
        low_cnt++;
        if (first_low == 0) first_low = kk;
      end
      if (!ce_n) bus_end = kk;
      if (cle) cle_cnt++;
      if (ale) ale_cnt++;
      if (done) begin done_cnt++; done_k = kk; done_rdy = ready; end
      if (kk <= t && ready) rdy_bad = 1;
      if (k != 2'd3 && !strobe && (!oe || dout != wd)) oe_bad = 1;
      if (k == 2'd3 && oe) oe_bad = 1;
      din = !re_n ? rd : ~rd;
      if (kk == flip_k) ready_pin = 1'b1;
    end
    chk(first_low == s + 2, "R2 setup length", first_low, s + 2);
    chk(low_cnt == w + 1 && !other_bad, "R3 pulse width", low_cnt, w + 1);
    chk(bus_end - (first_low + low_cnt - 1) == h + 1, "R4 hold length",
        bus_end - (first_low + low_cnt - 1), h + 1);
    chk(done_cnt == 1 && done_k == t + 1, "R5 done timing", done_k, t + 1);
    chk(cle_cnt == (k == 2'd0 ? bus : 0), "R6 cle span", cle_cnt, k == 2'd0 ? bus : 0);
    chk(ale_cnt == (k == 2'd1 ? bus : 0), "R6 ale span", ale_cnt, k == 2'd1 ? bus : 0);
    if (k == 2'd3) chk(rdata == rd && !oe_bad, "R7 read capture", rdata, rd);
    else chk(!oe_bad, "R7 write drive", oe_bad, 0);
    chk(!rdy_bad, "R8 ready frozen", rdy_bad, 0);
    chk(done_rdy == (flip_k > 0 && flip_k <= t), "R8 ready sample", done_rdy,
        (flip_k > 0 && flip_k <= t));
    chk(!acc1 && acc_end, "R9 accept busy/idle", {acc1, acc_end}, 2'b01);
    ready_pin = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_backlog;
    int done_cnt = 0, cle_cnt = 0, ale_cnt = 0, ale_after = 0;
    timing = '0;
    @(negedge clk);
    kind = 2'd0; wdata = 8'h11; req = 1'b1;
    @(negedge clk);
    chk(!accept, "R9 accept low when busy", accept, 0);
    kind = 2'd1; wdata = 8'h22;
    @(negedge clk);
    req = 1'b0;
    for (int kk = 0; kk < 30; kk++) begin
      if (cle) cle_cnt++;
      if (ale) begin ale_cnt++; if (done_cnt > 0) ale_after++; end
      if (done) done_cnt++;
      @(negedge clk);
    end
    chk(done_cnt == 2, "R9 both cycles done", done_cnt, 2);
    chk(cle_cnt == 2 && ale_cnt == 3 && ale_after == 3, "R9 parked addr after cmd", ale_after, 3);
  endtask

  task automatic t_force;
    bit ce_hi = 0;
    int done_cnt = 0;
    force_ce = 1'b1;
    timing = mk(1, 1, 1, 2, 0, 0, 0, 0);
    @(negedge clk);
    kind = 2'd2; wdata = 8'h5a; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int kk = 0; kk < 25; kk++) begin
      if (ce_n) ce_hi = 1;
      if (done) done_cnt++;
      @(negedge clk);
    end
    chk(!ce_hi && done_cnt == 1, "R10 ce held across cycle and idle", ce_hi, 0);
    force_ce = 1'b0;
    @(negedge clk);
    chk(ce_n, "R10 ce released", ce_n, 1);
  endtask

  task automatic t_soft_rst;
    bit bad = 0;
    timing = mk(0, 0, 0, 0, 6, 2, 2, 3);
    @(negedge clk);
    kind = 2'd3; req = 1'b1;
    @(negedge clk);
    kind = 2'd0; // second request gets parked
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(re_n && we_n && ce_n && accept, "R11 aborted to idle", {re_n, we_n, ce_n, accept}, 4'b1111);
    for (int kk = 0; kk < 40; kk++) begin
      if (done || !re_n || !we_n || cle) bad = 1;
      @(negedge clk);
    end
    chk(!bad, "R11 no activity after abort", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    // command: write group, ready flips in last wait clock
    run_cycle(2'd0, 8'h70, mk(1, 0, 2, 1, 9, 9, 9, 9), 7, 8'h00);
    // address: no wait, ready never rises
    run_cycle(2'd1, 8'h3c, mk(0, 3, 0, 0, 5, 5, 5, 5), 0, 8'h00);
    // data write at maximum fields, ready rises early and must stay frozen
    run_cycle(2'd2, 8'ha5, mk(15, 15, 15, 15, 0, 0, 0, 0), 2, 8'h00);
    // data read uses read group only
    run_cycle(2'd3, 8'h00, mk(7, 7, 7, 7, 2, 1, 3, 2), 0, 8'hc3);
    run_cycle(2'd3, 8'h00, mk(0, 0, 0, 0, 0, 0, 0, 0), 3, 8'h96);
    // ready flips one clock too late
    run_cycle(2'd2, 8'h0f, mk(0, 0, 0, 1, 0, 0, 0, 0), 6, 8'h00);
    t_backlog();
    t_force();
    t_soft_rst();
    ready_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready, "R8 idle tracks pin", ready, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule